// File: doc/BRIEF.md
# Reverse-Carry Address Generator

This block keeps one address register and one unsigned index register and updates the address whenever it is told to step. In bit-reversed mode the index is added to the address with the carry travelling from each bit into the next lower bit, not the next higher one. Repeated steps from an aligned base therefore visit a table in bit-reversed order, which is how the output of a radix-2 FFT is read back in natural order without moving any data. In linear mode the same step is an ordinary forward add, so both walks can be run on the same hardware and compared.

For a table of 2^n entries with real and imaginary parts in separate arrays, software loads an index of 2^(n-1) and a base whose n low bits are zero. For interleaved real and imaginary words it loads an index of 2^n and a base whose n+1 low bits are zero. The register width is a parameter (default 16, covering tables of up to 64K entries).

Top module: `rev_carry_agen`

## Requirements
- R1: While reset is asserted and after its release, `addr_out` and the internal index are zero until a load occurs.
- R2: When `addr_ld` is high at a rising edge, `addr_out` shows `addr_ld_val` after that edge.
- R3: When `idx_ld` is high at a rising edge, `idx_ld_val` (treated as unsigned) becomes the step used by every later step.
- R4: With `rev_mode` = 1, a step replaces the address with the reverse-carry sum of address and index: bit i gets a XOR b XOR c(i), and the carry out of bit i enters bit i-1; bit W-1 receives no carry. The result equals bit-reversing both operands, adding them normally modulo 2^W and bit-reversing the sum. `addr_out` shows it one clock after the step strobe.
- R5: In reverse-carry mode a carry leaving bit 0 is discarded (address 0x0001 plus index 0x0001 gives 0x0000; 0x8000 plus 0x8000 gives 0x4000).
- R6: In reverse-carry mode, address bits above the highest set bit of the index never change; from base 96 with index 8 the walk is 96, 104, 100, 108, 98, 106, 102, 110, 97, 105, 101, 109, 99, 107, 103, 111 and returns to 96 on the sixteenth step.
- R7: With `rev_mode` = 0, a step replaces the address with address plus index modulo 2^W (0xFFFF plus 1 gives 0x0000 at W = 16).
- R8: A load of either register in the same cycle as a step cancels the step: the address takes the loaded value if `addr_ld` is high, and otherwise stays unchanged.
- R9: With no step and no load, the address holds its value.
- R10: The mode is sampled on each step, so reverse-carry and linear steps can be mixed freely on the same register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load the address register |
| addr_ld_val | input | W | Value for the address load |
| idx_ld | input | 1 | Load the index register |
| idx_ld_val | input | W | Value for the index load (unsigned) |
| step | input | 1 | Apply one address update |
| rev_mode | input | 1 | 1 = reverse-carry add, 0 = forward add |
| addr_out | output | W | Current address register |

## Verification
Every result of this block is due exactly one rising edge after the cycle that carries the load or step, since only the address and index registers lie between the inputs and `addr_out`. The bench drives each command on a falling edge, lets one rising edge pass and compares `addr_out` on the following falling edge against a shadow model that updates on the same edge, so each check samples the register just after the edge that was meant to change it. Index loads are observed through the next step's result, and cancelled or idle cycles are checked by the address not moving.

// File: rtl/rcag_pkg.sv
package rcag_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,
        ACT_LOAD_A   = 3'd1,
        ACT_LOAD_I   = 3'd2,
        ACT_LOAD_AI  = 3'd3,
        ACT_STEP_REV = 3'd4,
        ACT_STEP_LIN = 3'd5
    } rcag_act_e;

endpackage

// File: rtl/rcag_rev_adder.sv
module rcag_rev_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    // cin[i] is the carry entering bit i; it comes from bit i+1.
    logic [W-1:0] cin;

    assign cin[W-1] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign s[i] = a[i] ^ b[i] ^ cin[i];
        if (i > 0) begin : g_carry
            assign cin[i-1] = (a[i] & b[i]) | (a[i] & cin[i]) | (b[i] & cin[i]);
        end
    end

    // R4: a zero index leaves the address unchanged
    always_comb begin
        if (b == '0) begin
            a_r4_zero_index: assert (s == a);
        end
    end

endmodule

// File: rtl/rcag_fwd_adder.sv
module rcag_fwd_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    // c[i] is the carry entering bit i; it comes from bit i-1.
    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i] = a[i] ^ b[i] ^ c[i];
        if (i < W - 1) begin : g_carry
            assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end

endmodule

// File: rtl/rcag_ctrl.sv
module rcag_ctrl
    import rcag_pkg::*;
(
    input  logic      addr_ld,
    input  logic      idx_ld,
    input  logic      step,
    input  logic      rev_mode,
    output rcag_act_e act
);
    always_comb begin
        if (addr_ld && idx_ld) begin
            act = ACT_LOAD_AI;
        end else if (addr_ld) begin
            act = ACT_LOAD_A;
        end else if (idx_ld) begin
            act = ACT_LOAD_I;
        end else if (step) begin
            act = rev_mode ? ACT_STEP_REV : ACT_STEP_LIN;
        end else begin
            act = ACT_HOLD;
        end
    end

    // R8: a load always wins over a step
    always_comb begin
        if (addr_ld || idx_ld) begin
            a_r8_load_first: assert (act != ACT_STEP_REV && act != ACT_STEP_LIN);
        end
    end

endmodule

// File: rtl/rev_carry_agen.sv
module rev_carry_agen
    import rcag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         addr_ld,
    input  logic [W-1:0] addr_ld_val,
    input  logic         idx_ld,
    input  logic [W-1:0] idx_ld_val,
    input  logic         step,
    input  logic         rev_mode,
    output logic [W-1:0] addr_out
);
    typedef struct packed {
        logic [W-1:0] addr;
        logic [W-1:0] idx;
    } regs_t;

    regs_t     regs_d, regs_q;
    rcag_act_e act;
    logic [W-1:0] rev_sum;
    logic [W-1:0] lin_sum;

    rcag_ctrl u_ctrl (
        .addr_ld  (addr_ld),
        .idx_ld   (idx_ld),
        .step     (step),
        .rev_mode (rev_mode),
        .act      (act)
    );

    rcag_rev_adder #(.W(W)) u_rev (
        .a (regs_q.addr),
        .b (regs_q.idx),
        .s (rev_sum)
    );

    rcag_fwd_adder #(.W(W)) u_fwd (
        .a (regs_q.addr),
        .b (regs_q.idx),
        .s (lin_sum)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (act)
            ACT_LOAD_A:   regs_d.addr = addr_ld_val;
            ACT_LOAD_I:   regs_d.idx  = idx_ld_val;
            ACT_LOAD_AI: begin
                regs_d.addr = addr_ld_val;
                regs_d.idx  = idx_ld_val;
            end
            ACT_STEP_REV: regs_d.addr = rev_sum;
            ACT_STEP_LIN: regs_d.addr = lin_sum;
            default:      regs_d = regs_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign addr_out = regs_q.addr;

    function automatic logic [W-1:0] fill_down(input logic [W-1:0] v);
        logic [W-1:0] r;
        r = v;
        for (int k = 0; k < W; k++) begin
            r = r | (r >> 1);
        end
        return r;
    endfunction

    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> addr_out == $past(addr_ld_val));

    a_r3_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ld |=> regs_q.idx == $past(idx_ld_val));

    a_r6_high_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rev_mode && !addr_ld && !idx_ld)
        |=> ((addr_out ^ $past(addr_out)) & ~fill_down($past(regs_q.idx))) == '0);

    a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rev_mode && !addr_ld && !idx_ld)
        |=> addr_out == W'($past(addr_out) + $past(regs_q.idx)));

    a_r8_idx_load_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ld && !addr_ld) |=> $stable(addr_out));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !addr_ld && !idx_ld) |=> $stable(addr_out));

endmodule

// File: tb/rev_carry_agen_test.sv
module rev_carry_agen_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         addr_ld = 1'b0;
    logic [W-1:0] addr_ld_val = '0;
    logic         idx_ld = 1'b0;
    logic [W-1:0] idx_ld_val = '0;
    logic         step = 1'b0;
    logic         rev_mode = 1'b0;
    logic [W-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_addr = '0;
    logic [W-1:0] m_idx  = '0;

    always #5 clk = ~clk;

    rev_carry_agen #(.W(W)) uut (
        .clk, .rst_n, .addr_ld, .addr_ld_val, .idx_ld, .idx_ld_val,
        .step, .rev_mode, .addr_out
    );

    function automatic logic [W-1:0] brev(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = v[W-1-k];
        return r;
    endfunction

    function automatic logic [W-1:0] rc_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] t;
        t = brev(a) + brev(b);
        return brev(t);
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // drive on falling edge, one rising edge, sample on next falling edge
    task automatic cmd(input logic al, input logic [W-1:0] av, input logic il,
                       input logic [W-1:0] iv, input logic st, input logic rm);
        addr_ld = al; addr_ld_val = av; idx_ld = il; idx_ld_val = iv;
        step = st; rev_mode = rm;
        if (al || il) begin
            if (al) m_addr = av;
            if (il) m_idx = iv;
        end else if (st) begin
            m_addr = rm ? rc_add(m_addr, m_idx) : m_addr + m_idx;
        end
        @(posedge clk);
        @(negedge clk);
        addr_ld = 1'b0; idx_ld = 1'b0; step = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: addr_out=%h expected=done", addr_out);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] walk [16];
        walk = '{16'd96, 16'd104, 16'd100, 16'd108, 16'd98, 16'd106, 16'd102, 16'd110,
                 16'd97, 16'd105, 16'd101, 16'd109, 16'd99, 16'd107, 16'd103, 16'd111};
        void'($urandom(32'd12345));
        repeat (2) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);
        cmd(0, '0, 0, '0, 1, 1);           // step with zero index
        check("R1", '0);

        cmd(1, 16'd96, 1, 16'd8, 0, 1);
        check("R2", 16'd96);
        for (int i = 1; i <= 16; i++) begin
            cmd(0, '0, 0, '0, 1, 1);
            check("R6", walk[i % 16]);
        end

        cmd(1, 16'h0001, 1, 16'h0001, 0, 1);
        cmd(0, '0, 0, '0, 1, 1);
        check("R5", 16'h0000);
        cmd(1, 16'h8000, 1, 16'h8000, 0, 1);
        cmd(0, '0, 0, '0, 1, 1);
        check("R5", 16'h4000);

        cmd(1, 16'hFFFF, 1, 16'h0001, 0, 0);
        cmd(0, '0, 0, '0, 1, 0);
        check("R7", 16'h0000);

        cmd(1, 16'h1234, 0, '0, 1, 1);
        check("R8", 16'h1234);
        cmd(0, '0, 1, 16'h0100, 1, 0);
        check("R8", 16'h1234);
        cmd(0, '0, 0, '0, 1, 0);
        check("R3", 16'h1334);
        cmd(0, '0, 0, '0, 0, 1);
        check("R9", 16'h1334);
        cmd(0, '0, 0, '0, 1, 1);
        check("R4", rc_add(16'h1334, 16'h0100));
        cmd(0, '0, 0, '0, 1, 0);
        check("R10", m_addr);

        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (r == 0)
                cmd(1, W'($urandom), 0, '0, W'($urandom_range(0, 1)), 1);
            else if (r == 1)
                cmd(0, '0, 1, W'($urandom), W'($urandom_range(0, 1)), 0);
            else if (r == 2)
                cmd(0, '0, 0, '0, 0, W'($urandom_range(0, 1)));
            else
                cmd(0, '0, 0, '0, 1, r > 4);
            check(r > 4 ? "R4" : (r > 2 ? "R7" : "R3"), m_addr);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule